// File: doc/BRIEF.md
# Carry-Sliced Pipelined Adder

This block adds two unsigned words and returns one result per clock. The carry chain is cut by registers at fixed slice boundaries, so in any one cycle a carry ripples through a single slice of `SW` bits. That slice sets the critical path, not the full word. Each slice's operand bits are held back one cycle per slice below it, so they arrive together with the registered carry from the slice beneath. Each slice's sum bits are then held back so that all slices of one sample leave together. The result is (A+B) mod 2^W after a fixed latency, and the final carry-out is dropped.

A parameter removes both the entry skew and the exit deskew. In that form the block works inside a datapath that is already skewed. Slice i of the operands must then belong to the sample offered i cycles earlier. Several such adders can be cascaded with one skew at the entry of the chain and one deskew at its exit. A valid flag travels beside the data with the same latency, as a tag only.

Top module: `pipe_carry_adder`

## Requirements
- R1: With skew enabled, `s` equals (`a`+`b`) mod 2^W for the operands presented NS cycles earlier, where NS = ceil(W/SW), and the carry out of bit W-1 is discarded.
- R2: A new operand pair is accepted every clock with no stall, and back-to-back distinct samples each produce their own correct sum.
- R3: A carry produced in any slice reaches every higher slice, including the full-width case all-ones plus one, which yields zero.
- R4: When W is not a multiple of SW, the top slice is W-(NS-1)*SW bits wide and the latency is still NS cycles.
- R5: `vOut` equals `vIn` delayed by the block latency, and `vIn` has no effect on `s`.
- R6: With `BYPASS`=1 the latency is one cycle per slice. Slice i occupies bits [i*SW +: SW]. Slice i of the inputs in cycle t must belong to sample t-i, and slice i of `s` one cycle later carries that sample's sum slice, including the carry from below.
- R7: Synchronous active-high `rst` clears every skew, carry, sum and valid register. Outputs for samples presented up to and including the reset cycle come out as zero sum with `vOut` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vIn | input | 1 | Valid tag for the operand pair |
| a | input | W | First operand |
| b | input | W | Second operand |
| s | output | W | Sum, modulo 2^W |
| vOut | output | 1 | Valid tag aligned with `s` |

## Verification
The bench builds three instances side by side. The first is W=16, SW=2: eight two-bit slices and an eight-cycle latency, which lets a carry walk through the whole skew triangle. The second is W=10, SW=4, which leaves a short two-bit top slice and a three-cycle latency. The third is W=12, SW=3 with bypass. The bench itself skews the operands for the third instance and reassembles its sum from four consecutive output cycles, which checks the one-cycle slice timing and the carry hand-off between slices directly.

// File: rtl/pca_pkg.sv
package pca_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
  } pcaCtl_t;

  function automatic int sliceCount(input int w, input int sw);
    return (w + sw - 1) / sw;
  endfunction

  function automatic int pipeLatency(input int ns, input bit bypass);
    return bypass ? 1 : ns;
  endfunction

endpackage

// File: rtl/pca_skew.sv
// Triangular delay array: lane i delayed by i (REVERSE=0) or NS-1-i (REVERSE=1).
module pca_skew
  import pca_pkg::*;
#(
  parameter int W       = 16,
  parameter int SW      = 2,
  parameter bit REVERSE = 1'b0
) (
  input  logic          clk,
  input  pcaCtl_t       ctl,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int NS = sliceCount(W, SW);

  for (genvar i = 0; i < NS; i++) begin : g_lane
    localparam int LW = (i == NS - 1) ? (W - (NS - 1) * SW) : SW;
    localparam int D  = REVERSE ? (NS - 1 - i) : i;
    if (D == 0) begin : g_pass
      assign dout[i*SW +: LW] = din[i*SW +: LW];
    end else begin : g_dly
      logic [LW-1:0] stg [D];
      always_ff @(posedge clk) begin
        if (ctl.clr) begin
          for (int k = 0; k < D; k++) stg[k] <= '0;
        end else begin
          stg[0] <= din[i*SW +: LW];
          for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
        end
      end
      assign dout[i*SW +: LW] = stg[D-1];
    end
  end

endmodule

// File: rtl/pca_slices.sv
// Slice adders with a registered carry between neighbours and a registered sum.
module pca_slices
  import pca_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  pcaCtl_t       ctl,
  input  logic [W-1:0]  aSk,
  input  logic [W-1:0]  bSk,
  output logic [W-1:0]  sSk
);
  localparam int NS = sliceCount(W, SW);
  localparam int LW = W - (NS - 1) * SW;

  logic [NS-1:0] carryNext;
  logic [NS-1:0] carryQ;
  logic [W-1:0]  sumNext;
  logic [W-1:0]  sumQ;

  assign carryNext[0] = 1'b0;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    if (i == NS - 1) begin : g_top
      assign sumNext[i*SW +: LW] = aSk[i*SW +: LW] + bSk[i*SW +: LW] + LW'(carryQ[i]);
    end else begin : g_low
      logic [SW:0] raw;
      assign raw = (SW+1)'(aSk[i*SW +: SW]) + (SW+1)'(bSk[i*SW +: SW])
                 + (SW+1)'(carryQ[i]);
      assign sumNext[i*SW +: SW] = raw[SW-1:0];
      assign carryNext[i+1]      = raw[SW];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      carryQ <= '0;
      sumQ   <= '0;
    end else begin
      carryQ <= carryNext;
      sumQ   <= sumNext;
    end
  end

  assign sSk = sumQ;

endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int W      = 16,
  parameter int SW     = 2,
  parameter bit BYPASS = 1'b0
) (
  input  logic          clk,
  input  pcaCtl_t       ctl,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  s
);
  logic [W-1:0] aSk, bSk, sSk;

  if (BYPASS) begin : g_direct
    assign aSk = a;
    assign bSk = b;
    assign s   = sSk;
  end else begin : g_skewed
    pca_skew #(.W(W), .SW(SW), .REVERSE(1'b0)) u_skewA (
      .clk(clk), .ctl(ctl), .din(a), .dout(aSk));
    pca_skew #(.W(W), .SW(SW), .REVERSE(1'b0)) u_skewB (
      .clk(clk), .ctl(ctl), .din(b), .dout(bSk));
    pca_skew #(.W(W), .SW(SW), .REVERSE(1'b1)) u_deskew (
      .clk(clk), .ctl(ctl), .din(sSk), .dout(s));
  end

  pca_slices #(.W(W), .SW(SW)) u_core (
    .clk(clk), .ctl(ctl), .aSk(aSk), .bSk(bSk), .sSk(sSk));

endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    vIn,
  output pcaCtl_t ctl,
  output logic    vOut
);
  logic [LAT-1:0] vPipe;

  assign ctl.clr = rst;

  if (LAT == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) vPipe <= '0;
      else     vPipe <= vIn;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) vPipe <= '0;
      else     vPipe <= {vPipe[LAT-2:0], vIn};
    end
  end

  assign vOut = vPipe[LAT-1];

endmodule

// File: rtl/pipe_carry_adder.sv
module pipe_carry_adder
  import pca_pkg::*;
#(
  parameter int W      = 16,
  parameter int SW     = 2,
  parameter bit BYPASS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vIn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         vOut
);
  localparam int NS  = sliceCount(W, SW);
  localparam int LAT = pipeLatency(NS, BYPASS);

  pcaCtl_t ctl;

  pca_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rst(rst), .vIn(vIn), .ctl(ctl), .vOut(vOut));

  pca_datapath #(.W(W), .SW(SW), .BYPASS(BYPASS)) u_dp (
    .clk(clk), .ctl(ctl), .a(a), .b(b), .s(s));

endmodule

// File: rtl/pca_checker.sv
module pca_checker
  import pca_pkg::*;
#(
  parameter int W      = 16,
  parameter int SW     = 2,
  parameter bit BYPASS = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         vIn,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] s,
  input logic         vOut
);
  localparam int NS  = sliceCount(W, SW);
  localparam int LAT = pipeLatency(NS, BYPASS);
  localparam int L0  = (W < SW) ? W : SW;

  logic         refV [LAT];
  logic [W-1:0] refS [LAT];
  logic [L0-1:0] lowRef;
  int           settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) begin
        refV[k] <= 1'b0;
        refS[k] <= '0;
      end
      lowRef <= '0;
      settle <= 0;
    end else begin
      refV[0] <= vIn;
      refS[0] <= a + b;
      for (int k = 1; k < LAT; k++) begin
        refV[k] <= refV[k-1];
        refS[k] <= refS[k-1];
      end
      lowRef <= a[L0-1:0] + b[L0-1:0];
      if (settle < LAT) settle <= settle + 1;
    end
  end

  // R5: valid tag delayed by the latency
  a_r5_valid_delay: assert property (@(posedge clk) disable iff (rst)
    vOut == refV[LAT-1]);

  // R7: first cycle after reset shows cleared outputs
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (s == '0 && !vOut));

  if (!BYPASS) begin : g_full
    // R1: sum of the sample NS cycles back once the pipe has refilled
    a_r1_sum_latency: assert property (@(posedge clk) disable iff (rst)
      (settle == LAT) |-> (s == refS[LAT-1]));
  end else begin : g_byp
    // R6: lowest slice has no carry-in and answers one cycle later
    a_r6_low_slice: assert property (@(posedge clk) disable iff (rst)
      s[L0-1:0] == lowRef);
  end

endmodule

bind pipe_carry_adder pca_checker #(.W(W), .SW(SW), .BYPASS(BYPASS)) u_chk (
  .clk(clk), .rst(rst), .vIn(vIn), .a(a), .b(b), .s(s), .vOut(vOut));

// File: tb/sim_pipe_carry_adder.sv
module sim_pipe_carry_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vIn = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [11:0] a2 = '0, b2 = '0;
  logic [15:0] s0;
  logic [9:0]  s1;
  logic [11:0] s2;
  logic v0o, v1o, v2o;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int lastRst = 0;
  bit done    = 1'b0;

  logic [15:0] hA [1024];
  logic [15:0] hB [1024];
  logic        hV [1024];
  logic [11:0] oS2 [1024];

  always #2 clk = ~clk;

  pipe_carry_adder #(.W(16), .SW(2), .BYPASS(1'b0)) u0 (
    .clk(clk), .rst(rst), .vIn(vIn), .a(a16), .b(b16), .s(s0), .vOut(v0o));

  pipe_carry_adder #(.W(10), .SW(4), .BYPASS(1'b0)) u1 (
    .clk(clk), .rst(rst), .vIn(vIn), .a(a16[9:0]), .b(b16[9:0]), .s(s1), .vOut(v1o));

  pipe_carry_adder #(.W(12), .SW(3), .BYPASS(1'b1)) u2 (
    .clk(clk), .rst(rst), .vIn(vIn), .a(a2), .b(b2), .s(s2), .vOut(v2o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock: check outputs due now, then drive the next sample
  task automatic step(input logic [15:0] av, input logic [15:0] bv,
                      input logic vv, input logic rr, input string tag);
    int k, sm;
    logic [15:0] e16;
    logic [9:0]  e10;
    logic [11:0] e12, asm;
    @(negedge clk);
    cyc++;
    k = cyc;
    // 16-bit, 8 slices, latency 8
    sm = k - 8;
    if (sm >= 1) begin
      e16 = (sm <= lastRst) ? 16'h0 : 16'(hA[sm & 1023] + hB[sm & 1023]);
      chk({tag, " u0 sum"}, 32'(s0), 32'(e16));
      chk({tag, " R5 u0 valid"}, 32'(v0o), (sm <= lastRst) ? 32'd0 : 32'(hV[sm & 1023]));
    end
    // 10-bit, 3 slices, latency 3
    sm = k - 3;
    if (sm >= 1) begin
      e10 = (sm <= lastRst) ? 10'h0 : 10'(hA[sm & 1023][9:0] + hB[sm & 1023][9:0]);
      chk({tag, " R4 u1 sum"}, 32'(s1), 32'(e10));
      chk({tag, " R5 u1 valid"}, 32'(v1o), (sm <= lastRst) ? 32'd0 : 32'(hV[sm & 1023]));
    end
    // bypass instance: latency one per slice, reassemble the sum
    oS2[k & 1023] = s2;
    sm = k - 1;
    if (sm >= 1)
      chk({tag, " R6 u2 valid"}, 32'(v2o), (sm <= lastRst) ? 32'd0 : 32'(hV[sm & 1023]));
    sm = k - 4;
    if (sm >= 1 && sm > lastRst) begin
      for (int i = 0; i < 4; i++) asm[i*3 +: 3] = oS2[(sm + i + 1) & 1023][i*3 +: 3];
      e12 = 12'(hA[sm & 1023][11:0] + hB[sm & 1023][11:0]);
      chk({tag, " R6 u2 sum"}, 32'(asm), 32'(e12));
    end
    // drive
    hA[k & 1023] = av;
    hB[k & 1023] = bv;
    hV[k & 1023] = vv;
    a16 = av;
    b16 = bv;
    vIn = vv;
    rst = rr;
    if (rr) lastRst = k;
    for (int i = 0; i < 4; i++) begin
      a2[i*3 +: 3] = hA[(k - i) & 1023][i*3 +: 3];
      b2[i*3 +: 3] = hB[(k - i) & 1023][i*3 +: 3];
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 10; i++) step(16'h0, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic tResetState;
    for (int i = 0; i < 3; i++) step(16'h0, 16'h0, 1'b0, 1'b1, "R7 reset");
    flush("R7 reset");
    chk("R7 u0 sum idle", 32'(s0), 32'd0);
    chk("R7 u0 valid idle", 32'(v0o), 32'd0);
  endtask

  task automatic tCarryRipple;
    step(16'hFFFF, 16'h0001, 1'b1, 1'b0, "R3 ripple");
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R3 ripple");
    step(16'h5555, 16'hAAAB, 1'b1, 1'b0, "R3 ripple");
    step(16'h7FFF, 16'h0001, 1'b1, 1'b0, "R3 ripple");
    step(16'h00FF, 16'h0001, 1'b1, 1'b0, "R3 ripple");
    step(16'h8000, 16'h8000, 1'b1, 1'b0, "R3 ripple");
    flush("R3 ripple");
  endtask

  task automatic tUneven;
    step(16'h03FF, 16'h0001, 1'b1, 1'b0, "R4 uneven");
    step(16'h023F, 16'h01C1, 1'b1, 1'b0, "R4 uneven");
    step(16'h00F0, 16'h0010, 1'b1, 1'b0, "R4 uneven");
    step(16'h03FF, 16'h03FF, 1'b1, 1'b0, "R4 uneven");
    flush("R4 uneven");
  endtask

  task automatic tBackToBack;
    for (int i = 0; i < 80; i++)
      step(16'($urandom), 16'($urandom), 1'b1, 1'b0, "R1 R2 stream");
    flush("R1 R2 stream");
  endtask

  task automatic tValidBubbles;
    for (int i = 0; i < 80; i++)
      step(16'($urandom), 16'($urandom), 1'($urandom), 1'b0, "R5 bubbles");
    flush("R5 bubbles");
  endtask

  task automatic tBypass;
    for (int i = 0; i < 60; i++)
      step(16'($urandom), 16'($urandom), 1'b1, 1'b0, "R6 bypass");
    step(16'h0FFF, 16'h0001, 1'b1, 1'b0, "R6 bypass");
    step(16'h0E38, 16'h01C8, 1'b1, 1'b0, "R6 bypass");
    flush("R6 bypass");
  endtask

  task automatic tMidReset;
    for (int i = 0; i < 20; i++)
      step(16'($urandom), 16'($urandom), 1'b1, 1'b0, "R7 mid");
    step(16'($urandom), 16'($urandom), 1'b1, 1'b1, "R7 mid");
    for (int i = 0; i < 20; i++)
      step(16'($urandom), 16'($urandom), 1'b1, 1'b0, "R7 mid");
    flush("R7 mid");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      hA[i] = '0;
      hB[i] = '0;
      hV[i] = 1'b0;
      oS2[i] = '0;
    end
    tResetState();
    tCarryRipple();
    tUneven();
    tBackToBack();
    tValidBubbles();
    tBypass();
    tMidReset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule